// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block is a bus master that runs write cycles to asynchronous external memory and to memory-mapped peripherals. An internal requester offers an address, a data word and a bank index over a ready/valid handshake. The block then plays out a fixed sequence of bus phases on a single internal clock. First comes a setup clock in which address and bank select become valid and an address clock pulse is given. A write strobe phase follows, then an optional address-hold clock, a closing clock, and an optional bus-idle clock.

The strobe lasts a two-clock base plus a programmed wait-state count of 0 to 7 clocks. After the wait states have elapsed, a synchronized external acknowledge can hold the strobe low for as long as the device needs. The data bus is modelled as a value plus an output-enable. The enable stays off on the clock the strobe falls and is released no later than the end of the hold clock. The wait count and the hold and idle options are captured together with each request.

Top module: `extmem_wr_seq`

## Requirements
- R1: While reset is high and on the first clock after it, mem_wr_n is 1, every bit of mem_sel_n is 1, mem_data_oe is 0, done is 0 and req_ready is 1.
- R2: req_ready is 1 only while no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both 1, and its address, data and bank are the values used by the access.
- R3: Each access begins with exactly one setup clock. In that clock mem_addr and mem_sel_n are valid, mem_wr_n is 1 and addr_clk is 1. addr_clk is 0 in every other clock.
- R4: With the synchronized acknowledge high, mem_wr_n is 0 for exactly 2 + W consecutive clocks, where W is the captured cfg_wait value.
- R5: ack_in passes through two flip-flops. The synchronized value is examined only from the (2 + W)th strobe clock on. While it is 0 there, the strobe stays low, and a low acknowledge seen before that clock has no effect on strobe length.
- R6: mem_data_oe is 0 in the first strobe clock. It is 1 from the second strobe clock to the last strobe clock, and in the hold clock. It is 0 in every other clock.
- R7: When the captured hold option is 1, one clock follows the strobe with mem_wr_n = 1 and address, select and driven data unchanged. When it is 0, no such clock exists.
- R8: After the strobe (and any hold clock) one closing clock keeps mem_sel_n active with mem_wr_n = 1 and mem_data_oe = 0. mem_addr does not change from the setup clock to the end of this clock.
- R9: When the captured idle option is 1, one clock with mem_sel_n all 1, mem_wr_n = 1 and mem_data_oe = 0 follows the closing clock before a new request can be taken.
- R10: done is 1 for exactly one clock, the last clock of the access: the closing clock, or the idle clock when the idle option is set.
- R11: Changes on cfg_wait, cfg_hold and cfg_idle after a request has been taken do not affect that access.
- R12: mem_sel_n is active low and one-hot. During an access, bit req_bank of the captured request is 0 and all other bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_bank | input | BANK_W | Index of the bank select to activate |
| cfg_wait | input | 3 | Wait-state count, 0 to 7 |
| cfg_hold | input | 1 | Insert an address-hold clock after the strobe |
| cfg_idle | input | 1 | Insert a bus-idle clock at the end of the access |
| ack_in | input | 1 | Asynchronous acknowledge, low stretches the strobe |
| done | output | 1 | One-clock pulse in the last clock of an access |
| mem_addr | output | ADDR_W | External address |
| mem_sel_n | output | NUM_BANKS | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_o | output | DATA_W | Write data value |
| mem_data_oe | output | 1 | Data bus driver enable, 0 means high impedance |
| addr_clk | output | 1 | Address clock, high in the setup clock |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that req_bank is always below NUM_BANKS, so that the select decode can only produce one active bit. The bench draws every bank index from that range. It changes inputs only at the falling clock edge, so the synchronizer and the request capture never see a change at the sampling edge. Acknowledge stretches are placed both inside and after the wait-state window, which covers the case where a low acknowledge must be ignored.

// File: rtl/extmem_wr_pkg.sv
package extmem_wr_pkg;

    localparam int WAIT_W      = 3;
    localparam int BASE_CYCLES = 2;
    localparam int CNT_W       = $clog2(BASE_CYCLES + (2 ** WAIT_W)) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_END,
        ST_GAP
    } wr_state_e;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              hold_en;
        logic              idle_en;
    } wr_cfg_t;

    function automatic wr_state_e next_after_strobe(wr_cfg_t c);
        return c.hold_en ? ST_HOLD : ST_END;
    endfunction

    function automatic wr_state_e next_after_end(wr_cfg_t c);
        return c.idle_en ? ST_GAP : ST_IDLE;
    endfunction

    function automatic logic [CNT_W-1:0] strobe_last(wr_cfg_t c);
        return CNT_W'(BASE_CYCLES - 1) + CNT_W'(c.waits);
    endfunction

endpackage

// File: rtl/extmem_ack_sync.sv
module extmem_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_async,
    output logic ack_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], ack_async};
        end
    end

    assign ack_sync = chain[STAGES-1];
endmodule

// File: rtl/extmem_wr_fsm.sv
module extmem_wr_fsm
    import extmem_wr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BANK_W-1:0] req_bank,
    input  wr_cfg_t           cfg_in,
    input  logic              ack_ok,
    output wr_state_e         state,
    output logic [CNT_W-1:0]  cnt,
    output wr_cfg_t           cfg_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cfg_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            bank_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        data_q <= req_data;
                        bank_q <= req_bank;
                        cfg_q  <= cfg_in;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt >= strobe_last(cfg_q) && ack_ok) begin
                        state <= next_after_strobe(cfg_q);
                    end else if (cnt != '1) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: state <= ST_END;
                ST_END:  state <= next_after_end(cfg_q);
                ST_GAP:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/extmem_bus_drv.sv
module extmem_bus_drv
    import extmem_wr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  wr_state_e             state,
    input  logic [CNT_W-1:0]      cnt,
    input  wr_cfg_t               cfg_q,
    input  logic [ADDR_W-1:0]     addr_q,
    input  logic [DATA_W-1:0]     data_q,
    input  logic [BANK_W-1:0]     bank_q,
    output logic                  req_ready,
    output logic                  done,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [NUM_BANKS-1:0]  mem_sel_n,
    output logic                  mem_wr_n,
    output logic [DATA_W-1:0]     mem_data_o,
    output logic                  mem_data_oe,
    output logic                  addr_clk
);
    logic                 on_bus;
    logic [NUM_BANKS-1:0] sel_dec;

    always_comb begin
        sel_dec = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            sel_dec[b] = (BANK_W'(b) == bank_q);
        end
    end

    always_comb begin
        on_bus      = (state == ST_SETUP) || (state == ST_STROBE) ||
                      (state == ST_HOLD)  || (state == ST_END);
        mem_sel_n   = on_bus ? ~sel_dec : '1;
        mem_wr_n    = (state != ST_STROBE);
        mem_data_oe = ((state == ST_STROBE) && (cnt != '0)) || (state == ST_HOLD);
        mem_data_o  = data_q;
        mem_addr    = addr_q;
        addr_clk    = (state == ST_SETUP);
        req_ready   = (state == ST_IDLE);
        done        = ((state == ST_END) && !cfg_q.idle_en) || (state == ST_GAP);
    end
endmodule

// File: rtl/extmem_wr_seq.sv
module extmem_wr_seq
    import extmem_wr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int SYNC_FF   = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [2:0]           cfg_wait,
    input  logic                 cfg_hold,
    input  logic                 cfg_idle,
    input  logic                 ack_in,
    output logic                 done,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_BANKS-1:0] mem_sel_n,
    output logic                 mem_wr_n,
    output logic [DATA_W-1:0]    mem_data_o,
    output logic                 mem_data_oe,
    output logic                 addr_clk
);
    wr_state_e         state;
    logic [CNT_W-1:0]  cnt;
    wr_cfg_t           cfg_in, cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BANK_W-1:0] bank_q;
    logic              ack_ok;

    assign cfg_in = '{waits: cfg_wait, hold_en: cfg_hold, idle_en: cfg_idle};

    extmem_ack_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst(rst), .ack_async(ack_in), .ack_sync(ack_ok)
    );

    extmem_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_bank(req_bank), .cfg_in(cfg_in),
        .ack_ok(ack_ok), .state(state), .cnt(cnt), .cfg_q(cfg_q),
        .addr_q(addr_q), .data_q(data_q), .bank_q(bank_q)
    );

    extmem_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
                     .BANK_W(BANK_W)) u_drv (
        .state(state), .cnt(cnt), .cfg_q(cfg_q), .addr_q(addr_q),
        .data_q(data_q), .bank_q(bank_q), .req_ready(req_ready), .done(done),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
        .mem_data_o(mem_data_o), .mem_data_oe(mem_data_oe), .addr_clk(addr_clk)
    );

    // R6: the bus is only driven during or right after a low strobe
    a_r6_oe_within_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_data_oe |-> (!mem_wr_n || $past(!mem_wr_n)));

    // R6: never driven in the clock the strobe falls
    a_r6_no_drive_at_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> !mem_data_oe);

    // R3: a setup clock with the address clock precedes every strobe
    a_r3_setup_first: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> $past(addr_clk));

    // R8: address unchanged while the strobe is low
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> $stable(mem_addr));

    // R12: at most one select active
    a_r12_onehot_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_sel_n));

    // R2: the bus is quiet whenever a request can be taken
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_wr_n && (&mem_sel_n) && !mem_data_oe));

    // R10: done lasts a single clock
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/test_extmem_wr_seq.sv
module test_extmem_wr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_bank = '0;
    logic [2:0]    cfg_wait = '0;
    logic          cfg_hold = 1'b0;
    logic          cfg_idle = 1'b0;
    logic          ack_in = 1'b1;
    logic          done;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_sel_n;
    logic          mem_wr_n;
    logic [DW-1:0] mem_data_o;
    logic          mem_data_oe;
    logic          addr_clk;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit started = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extmem_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB)) i_extmem_wr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_idle(cfg_idle),
        .ack_in(ack_in), .done(done), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_wr_n(mem_wr_n), .mem_data_o(mem_data_o), .mem_data_oe(mem_data_oe),
        .addr_clk(addr_clk)
    );

    // Behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 hold, 4 closing, 5 idle gap
    int            m_phase = 0;
    int            m_len   = 0;
    int            m_w     = 0;
    bit            m_h = 0, m_i = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    int            m_bank = 0;
    bit            ack_hist[$];

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_phase = 0; m_len = 0; m_w = 0; m_h = 0; m_i = 0;
            m_addr = '0; m_data = '0; m_bank = 0;
            ack_hist = '{1'b1, 1'b1};
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                       m_addr = req_addr; m_data = req_data; m_bank = int'(req_bank);
                       m_w = int'(cfg_wait); m_h = cfg_hold; m_i = cfg_idle;
                       m_phase = 1;
                   end
                1: begin m_phase = 2; m_len = 1; end
                2: if (m_len >= 2 + m_w && ack_hist[0]) m_phase = m_h ? 3 : 4;
                   else m_len++;
                3: m_phase = 4;
                4: m_phase = m_i ? 5 : 0;
                default: m_phase = 0;
            endcase
            void'(ack_hist.pop_front());
            ack_hist.push_back(ack_in);
        end
    end

    task automatic report(string req, string sig, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            bit            act_bus;
            logic [NB-1:0] e_sel;
            act_bus = (m_phase >= 1 && m_phase <= 4);
            e_sel = act_bus ? ~(NB'(1) << m_bank) : '1;
            report("R2", "req_ready", req_ready, m_phase == 0);
            report(m_phase == 5 ? "R9" : "R12 R8", "mem_sel_n", mem_sel_n, e_sel);
            report("R4 R5 R11", "mem_wr_n", mem_wr_n, m_phase != 2);
            report(m_phase == 3 ? "R7" : "R6", "mem_data_oe", mem_data_oe,
                   (m_phase == 2 && m_len >= 2) || m_phase == 3);
            report("R3", "addr_clk", addr_clk, m_phase == 1);
            report("R10", "done", done, (m_phase == 4 && !m_i) || m_phase == 5);
            report("R8", "mem_addr", mem_addr, m_addr);
            if (mem_data_oe) report("R7 R2", "mem_data_o", mem_data_o, m_data);
        end
    end

    task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d, input int bank,
                         input int w, input bit h, input bit i, input int dly, input int len);
        req_valid = 1'b1; req_addr = a; req_data = d; req_bank = 2'(bank);
        cfg_wait = 3'(w); cfg_hold = h; cfg_idle = i;
        do @(negedge clk); while (m_phase == 0);
        req_valid = 1'b0;
        // R11: scramble configuration once the request has been taken
        cfg_wait = ~cfg_wait; cfg_hold = ~cfg_hold; cfg_idle = ~cfg_idle;
        repeat (dly) @(negedge clk);
        if (len > 0) begin
            ack_in = 1'b0;
            repeat (len) @(negedge clk);
            ack_in = 1'b1;
        end
        while (m_phase != 0) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        report("R1", "reset mem_wr_n", mem_wr_n, 1);
        report("R1", "reset mem_sel_n", mem_sel_n, {NB{1'b1}});
        report("R1", "reset mem_data_oe", mem_data_oe, 0);
        report("R1", "reset done", done, 0);
        report("R1", "reset req_ready", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        issue(16'h1234, 16'hA5A5, 0, 0, 0, 0, 0, 0);
        issue(16'h2345, 16'h5A5A, 1, 3, 1, 0, 0, 0);
        issue(16'h3456, 16'hF00F, 2, 7, 0, 1, 0, 0);
        // R5: acknowledge held low past the wait window stretches the strobe
        issue(16'h4567, 16'h0FF0, 3, 2, 1, 1, 1, 8);
        // R5: an early short low is ignored
        issue(16'h5678, 16'h1111, 1, 5, 0, 0, 0, 2);
        for (int k = 0; k < 32; k++) begin
            issue(AW'(k * 16'h0111), DW'(16'hC000 ^ (k * 16'h0203)), k % NB, k % 8,
                  k[0], k[1], k % 5, k % 4);
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule